// File: doc/BRIEF.md
# Partial-Width General-Purpose Register File

This block holds sixteen 64-bit general-purpose registers behind two read ports and one write port. Each port carries a size code, so an access can cover the lowest 1, 2, 4 or all 8 bytes of a register. Register 4 is ordinary storage with no special role. Instruction decode, memory and flags sit outside the block.

A narrow write is merged into the register's existing contents. A 1-byte or 2-byte write keeps every byte above it. A 4-byte write clears the upper half. An 8-byte write replaces the whole register. The write port can also widen a smaller source. It takes the lowest bytes of the source, fills the bits above them with zeros or with copies of the source's top bit, and then applies the merge rule of the destination size.

A widening request whose destination is not larger than its source is refused. The block raises an error flag in the same cycle and leaves the register as it was. Reads are combinational from the stored state. A read of the register being written in that cycle returns the value from before the clock edge.

Top module: `narrow_gpr_file`

## Requirements
- R1: Sixteen 64-bit registers. A synchronous reset, held over a rising edge, sets every register to zero.
- R2: Read size codes are 0 = 1 byte, 1 = 2 bytes, 2 = 4 bytes and 3 = 8 bytes. A read returns that many low-order bytes of the addressed register. All data bits above them are zero.
- R3: A plain write (mode 0) of size 0 or 1 replaces only the lowest 1 or 2 bytes. Every higher byte keeps its old value.
- R4: A plain write of size 2 stores the low 4 bytes and forces bits 63:32 to zero. A plain write of size 3 replaces all 64 bits.
- R5: In zero-extend mode (mode 1), the source is the lowest (1 << src_size) bytes of the write data, and every bit above the source is zero. The result then follows the merge rule of the destination size: sizes 0 and 1 keep the old bytes above the destination, size 2 clears bits 63:32, and size 3 writes all 64 bits.
- R6: In sign-extend mode (mode 2), every bit above the source is a copy of the source's top bit. The destination merge rule is the same as in R5.
- R7: A write is refused when the mode is 1 or 2 and the destination size code is not greater than the source size code, or when the mode is 3. A refused write raises wr_err in the same cycle and leaves the register unchanged.
- R8: A read of the register being written in the same cycle returns the old value. The new value is visible from the next cycle. The two read ports are independent.
- R9: Zero-extending a 4-byte source to 8 bytes gives the same register value as a plain 4-byte write of the same data.
- R10: When wr_en is low, no register changes and wr_err is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| wr_en | input | 1 | Write request |
| wr_addr | input | 4 | Destination register |
| wr_data | input | 64 | Write data (source in its low bytes) |
| wr_size | input | 2 | Destination size code |
| wr_src_size | input | 2 | Source size code (used only when extending) |
| wr_mode | input | 2 | 0 plain, 1 zero-extend, 2 sign-extend, 3 reserved |
| wr_err | output | 1 | Illegal write request this cycle |
| rd0_addr | input | 4 | Read port 0 register |
| rd0_size | input | 2 | Read port 0 size code |
| rd0_data | output | 64 | Read port 0 data, zero above the size |
| rd1_addr | input | 4 | Read port 1 register |
| rd1_size | input | 2 | Read port 1 size code |
| rd1_data | output | 64 | Read port 1 data, zero above the size |

## Verification
The bench targets the byte boundaries where a merge rule changes:
- A design that cleared upper bytes on a 1-byte or 2-byte write would lose the old contents.
- A design that kept the upper half on a 4-byte write would leave stale bits 63:32.

Sign extension is driven with a source whose top bit is set and with one whose top bit is clear, and into destinations of every size. This catches a fill taken from the wrong bit and a 4-byte destination that wrongly keeps its upper half. Refused combinations (equal sizes, shrinking sizes, the reserved mode) are checked both for the error flag and for an unchanged register. A reversed legality check would corrupt registers silently. The bench also writes and reads the same register in one cycle, to catch a bypass that returns the new data too early.

// File: rtl/ngpr_pkg.sv
package ngpr_pkg;

    localparam int GPR_W      = 64;
    localparam int GPR_BYTES  = GPR_W / 8;

    typedef enum logic [1:0] {
        SZ_BYTE = 2'd0,
        SZ_HALF = 2'd1,
        SZ_WORD = 2'd2,
        SZ_FULL = 2'd3
    } gpr_size_e;

    typedef enum logic [1:0] {
        WM_PLAIN = 2'd0,
        WM_ZEXT  = 2'd1,
        WM_SEXT  = 2'd2,
        WM_RSVD  = 2'd3
    } gpr_mode_e;

    function automatic logic [GPR_W-1:0] size_mask(input gpr_size_e sz);
        logic [GPR_W-1:0] m;
        m = '0;
        for (int b = 0; b < GPR_BYTES; b++) begin
            if (b < (1 << sz)) m[b*8 +: 8] = 8'hFF;
        end
        return m;
    endfunction

endpackage

// File: rtl/ngpr_read_port.sv
module ngpr_read_port
    import ngpr_pkg::*;
(
    input  logic [GPR_W-1:0] reg_val,
    input  logic [1:0]       size,
    output logic [GPR_W-1:0] data
);
    always_comb begin
        data = reg_val & size_mask(gpr_size_e'(size));
    end
endmodule

// File: rtl/ngpr_write_merge.sv
module ngpr_write_merge
    import ngpr_pkg::*;
(
    input  logic [GPR_W-1:0] old_val,
    input  logic [GPR_W-1:0] data,
    input  logic [1:0]       dst_size,
    input  logic [1:0]       src_size,
    input  logic [1:0]       mode,
    output logic [GPR_W-1:0] new_val,
    output logic             illegal
);
    gpr_size_e        dst_e, src_e;
    gpr_mode_e        mode_e;
    logic [GPR_W-1:0] src_mask, dst_mask, widened;
    logic             src_top;

    always_comb begin
        dst_e    = gpr_size_e'(dst_size);
        src_e    = gpr_size_e'(src_size);
        mode_e   = gpr_mode_e'(mode);
        src_mask = size_mask(src_e);
        dst_mask = size_mask(dst_e);
        src_top  = data[(8 << src_size) - 1];

        unique case (mode_e)
            WM_PLAIN: begin
                illegal = 1'b0;
                widened = data;
            end
            WM_ZEXT: begin
                illegal = (dst_size <= src_size);
                widened = data & src_mask;
            end
            WM_SEXT: begin
                illegal = (dst_size <= src_size);
                widened = (data & src_mask) | (src_top ? ~src_mask : '0);
            end
            default: begin
                illegal = 1'b1;
                widened = data;
            end
        endcase

        unique case (dst_e)
            SZ_BYTE, SZ_HALF: new_val = (widened & dst_mask) | (old_val & ~dst_mask);
            SZ_WORD:          new_val = widened & dst_mask;
            default:          new_val = widened;
        endcase

        if (illegal) new_val = old_val;
    end
endmodule

// File: rtl/narrow_gpr_file.sv
module narrow_gpr_file
    import ngpr_pkg::*;
#(
    parameter int NUM_REGS = 16,
    parameter int N_RD     = 2,
    localparam int AW      = $clog2(NUM_REGS)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             wr_en,
    input  logic [AW-1:0]    wr_addr,
    input  logic [GPR_W-1:0] wr_data,
    input  logic [1:0]       wr_size,
    input  logic [1:0]       wr_src_size,
    input  logic [1:0]       wr_mode,
    output logic             wr_err,
    input  logic [AW-1:0]    rd0_addr,
    input  logic [1:0]       rd0_size,
    output logic [GPR_W-1:0] rd0_data,
    input  logic [AW-1:0]    rd1_addr,
    input  logic [1:0]       rd1_size,
    output logic [GPR_W-1:0] rd1_data
);
    logic [GPR_W-1:0] regs [NUM_REGS];
    logic [GPR_W-1:0] merged;
    logic             illegal;

    logic [AW-1:0]    rp_addr [N_RD];
    logic [1:0]       rp_size [N_RD];
    logic [GPR_W-1:0] rp_data [N_RD];

    assign rp_addr[0] = rd0_addr;
    assign rp_addr[1] = rd1_addr;
    assign rp_size[0] = rd0_size;
    assign rp_size[1] = rd1_size;
    assign rd0_data   = rp_data[0];
    assign rd1_data   = rp_data[1];

    ngpr_write_merge u_merge (
        .old_val  (regs[wr_addr]),
        .data     (wr_data),
        .dst_size (wr_size),
        .src_size (wr_src_size),
        .mode     (wr_mode),
        .new_val  (merged),
        .illegal  (illegal)
    );

    assign wr_err = wr_en & illegal;

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < NUM_REGS; i++) regs[i] <= '0;
        end else if (wr_en && !illegal) begin
            regs[wr_addr] <= merged;
        end
    end

    for (genvar p = 0; p < N_RD; p++) begin : g_rd
        ngpr_read_port u_rd (
            .reg_val (regs[rp_addr[p]]),
            .size    (rp_size[p]),
            .data    (rp_data[p])
        );
    end
endmodule

// File: rtl/ngpr_checker.sv
module ngpr_checker
    import ngpr_pkg::*;
#(
    parameter int NUM_REGS = 16,
    localparam int AW      = $clog2(NUM_REGS)
) (
    input logic             clk,
    input logic             rst,
    input logic             wr_en,
    input logic [AW-1:0]    wr_addr,
    input logic [GPR_W-1:0] wr_data,
    input logic [1:0]       wr_size,
    input logic [1:0]       wr_src_size,
    input logic [1:0]       wr_mode,
    input logic             wr_err,
    input logic [1:0]       rd0_size,
    input logic [GPR_W-1:0] rd0_data,
    input logic [GPR_W-1:0] regs [NUM_REGS]
);
    // R10: no error flag without a write request
    assert_err_needs_en_R10: assert property (@(posedge clk) disable iff (rst)
        !wr_en |-> !wr_err);

    // R7: refused write leaves the register untouched
    assert_refused_keeps_R7: assert property (@(posedge clk) disable iff (rst)
        wr_err |=> regs[$past(wr_addr)] == $past(regs[wr_addr]));

    // R3: plain byte write keeps bytes 7..1
    assert_byte_merge_R3: assert property (@(posedge clk) disable iff (rst)
        (wr_en && wr_mode == 2'd0 && wr_size == 2'd0) |=>
        (regs[$past(wr_addr)][63:8] == $past(regs[wr_addr][63:8]) &&
         regs[$past(wr_addr)][7:0]  == $past(wr_data[7:0])));

    // R4: plain 4-byte write clears the upper half
    assert_word_clear_R4: assert property (@(posedge clk) disable iff (rst)
        (wr_en && wr_mode == 2'd0 && wr_size == 2'd2) |=>
        regs[$past(wr_addr)][63:32] == 32'h0);

    // R6: byte-to-full sign extension fills from bit 7
    assert_sext_fill_R6: assert property (@(posedge clk) disable iff (rst)
        (wr_en && wr_mode == 2'd2 && wr_src_size == 2'd0 && wr_size == 2'd3) |=>
        regs[$past(wr_addr)][63:8] == {56{$past(wr_data[7])}});

    // R2: a one-byte read is zero above bit 7
    assert_read_pad_R2: assert property (@(posedge clk) disable iff (rst)
        rd0_size == 2'd0 |-> rd0_data[63:8] == 56'h0);
endmodule

bind narrow_gpr_file ngpr_checker #(.NUM_REGS(NUM_REGS)) u_ngpr_chk (
    .clk         (clk),
    .rst         (rst),
    .wr_en       (wr_en),
    .wr_addr     (wr_addr),
    .wr_data     (wr_data),
    .wr_size     (wr_size),
    .wr_src_size (wr_src_size),
    .wr_mode     (wr_mode),
    .wr_err      (wr_err),
    .rd0_size    (rd0_size),
    .rd0_data    (rd0_data),
    .regs        (regs)
);

// File: tb/tb_narrow_gpr_file.sv
module tb_narrow_gpr_file;
    localparam int CLK_P = 10;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        wr_en = 1'b0;
    logic [3:0]  wr_addr = '0;
    logic [63:0] wr_data = '0;
    logic [1:0]  wr_size = '0, wr_src_size = '0, wr_mode = '0;
    logic        wr_err;
    logic [3:0]  rd0_addr = '0, rd1_addr = '0;
    logic [1:0]  rd0_size = 2'd3, rd1_size = 2'd3;
    logic [63:0] rd0_data, rd1_data;

    int  n_tests = 0;
    int  n_fail  = 0;
    bit  done    = 0;
    logic [63:0] model [16];

    always #(CLK_P/2) clk = ~clk;

    narrow_gpr_file dut (
        .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .wr_size(wr_size), .wr_src_size(wr_src_size), .wr_mode(wr_mode), .wr_err(wr_err),
        .rd0_addr(rd0_addr), .rd0_size(rd0_size), .rd0_data(rd0_data),
        .rd1_addr(rd1_addr), .rd1_size(rd1_size), .rd1_data(rd1_data)
    );

    task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    function automatic logic [63:0] model_read(input logic [63:0] v, input int sz);
        logic [63:0] r = '0;
        for (int k = 0; k < (1 << sz); k++) r[k*8 +: 8] = v[k*8 +: 8];
        return r;
    endfunction

    function automatic void model_write(input logic [63:0] old, input logic [63:0] d,
                                        input int dsz, input int ssz, input int md,
                                        output logic [63:0] nv, output bit bad);
        int db = 1 << dsz;
        int sb = 1 << ssz;
        logic [7:0] fill;
        logic [7:0] b;
        bad = (md == 3) || ((md == 1 || md == 2) && db <= sb);
        nv = old;
        if (bad) return;
        if (md == 0) sb = 8;
        fill = (md == 2 && d[8*sb-1]) ? 8'hFF : 8'h00;
        for (int k = 0; k < 8; k++) begin
            b = (k < sb) ? d[k*8 +: 8] : fill;
            if (k < db)       nv[k*8 +: 8] = b;
            else if (db == 4) nv[k*8 +: 8] = 8'h00;
        end
    endfunction

    // one cycle: drive at falling edge, check before the rising edge, update model after it
    task automatic step(input string tag, input bit we, input int wa, input logic [63:0] wd,
                        input int ws, input int ss, input int md,
                        input int ra0, input int rs0, input int ra1, input int rs1);
        logic [63:0] nv;
        bit bad;
        @(negedge clk);
        wr_en = we; wr_addr = 4'(wa); wr_data = wd;
        wr_size = 2'(ws); wr_src_size = 2'(ss); wr_mode = 2'(md);
        rd0_addr = 4'(ra0); rd0_size = 2'(rs0); rd1_addr = 4'(ra1); rd1_size = 2'(rs1);
        model_write(model[wa], wd, ws, ss, md, nv, bad);
        #1;
        check({tag, " rd0"}, rd0_data, model_read(model[ra0], rs0));
        check({tag, " rd1"}, rd1_data, model_read(model[ra1], rs1));
        check({tag, " err"}, {63'b0, wr_err}, {63'b0, we && bad});
        @(posedge clk);
        if (we && !bad) model[wa] = nv;
    endtask

    task automatic wr(input string tag, input int wa, input logic [63:0] wd,
                      input int ws, input int ss, input int md);
        step(tag, 1, wa, wd, ws, ss, md, wa, 3, wa, 3);
    endtask

    task automatic rd_full(input string tag, input int a);
        step(tag, 0, 0, 64'h0, 3, 0, 0, a, 3, a, 3);
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    endtask

    initial begin
        #(CLK_P * 200000);
        n_tests++; n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        for (int i = 0; i < 16; i++) model[i] = '0;
        repeat (3) @(posedge clk);
        @(negedge clk) rst = 1'b0;

        // R1: all registers cleared by reset
        for (int i = 0; i < 16; i += 2) step("R1 reset", 0, 0, 0, 3, 0, 0, i, 3, i + 1, 3);

        // R4: full writes, then R2 narrow reads of every size
        for (int i = 0; i < 16; i++) wr("R4 full", i, {32'hA5C3_0F1E, 28'h0, 4'(i)} ^ 64'h8877_6655_4433_2211, 3, 0, 0);
        for (int s = 0; s < 4; s++) step("R2 narrow read", 0, 0, 0, 3, 0, 0, 5, s, 9, 3 - s);

        // R3: byte and half writes keep upper bytes
        wr("R3 byte", 3, 64'hFFFF_FFFF_FFFF_FF7E, 0, 0, 0);
        rd_full("R3 byte readback", 3);
        wr("R3 half", 3, 64'h1234_5678_9ABC_BEEF, 1, 0, 0);
        rd_full("R3 half readback", 3);

        // R4: plain word write clears upper half
        wr("R4 word", 6, 64'hDEAD_BEEF_CAFE_F00D, 2, 0, 0);
        rd_full("R4 word readback", 6);

        // R5: zero extension into each destination
        wr("R5 zx b->h", 7, 64'hFFFF_FFFF_FFFF_FF80, 1, 0, 1);
        rd_full("R5 zx b->h readback", 7);
        wr("R5 zx b->w", 8, 64'hFFFF_FFFF_FFFF_FF80, 2, 0, 1);
        rd_full("R5 zx b->w readback", 8);
        wr("R5 zx h->f", 10, 64'hFFFF_FFFF_FFFF_8001, 3, 1, 1);
        rd_full("R5 zx h->f readback", 10);

        // R6: sign extension, negative and positive sources
        wr("R6 sx b->f neg", 11, 64'h0000_0000_0000_0090, 3, 0, 2);
        rd_full("R6 sx b->f neg readback", 11);
        wr("R6 sx b->f pos", 12, 64'hFFFF_FFFF_FFFF_FF70, 3, 0, 2);
        rd_full("R6 sx b->f pos readback", 12);
        wr("R6 sx h->w neg", 13, 64'h0000_0000_0000_8000, 2, 1, 2);
        rd_full("R6 sx h->w neg readback", 13);
        wr("R6 sx b->h neg", 14, 64'h0000_0000_0000_00FF, 1, 0, 2);
        rd_full("R6 sx b->h neg readback", 14);
        wr("R6 sx w->f neg", 15, 64'h0000_0000_8000_0001, 3, 2, 2);
        rd_full("R6 sx w->f neg readback", 15);

        // R7: refused combinations leave register alone
        wr("R7 sx equal", 4, 64'hFFFF_FFFF_FFFF_FFFF, 1, 1, 2);
        rd_full("R7 sx equal unchanged", 4);
        wr("R7 zx shrink", 4, 64'h0, 0, 2, 1);
        rd_full("R7 zx shrink unchanged", 4);
        wr("R7 reserved", 4, 64'h0, 3, 0, 3);
        rd_full("R7 reserved unchanged", 4);

        // R9: zx word->full equals plain word write
        wr("R9 zx w->f", 2, 64'h7777_7777_F123_4567, 3, 2, 1);
        rd_full("R9 zx w->f readback", 2);
        wr("R9 plain word", 1, 64'h7777_7777_F123_4567, 2, 0, 0);
        step("R9 compare", 0, 0, 0, 3, 0, 0, 1, 3, 2, 3);

        // R8: read of register under write returns old value
        step("R8 same-cycle", 1, 5, 64'h0102_0304_0506_0708, 3, 0, 0, 5, 3, 5, 0);
        rd_full("R8 after edge", 5);

        // R10: disabled write with illegal fields changes nothing
        step("R10 no enable", 0, 9, 64'h0, 3, 3, 3, 9, 3, 9, 3);
        rd_full("R10 unchanged", 9);

        // mixed traffic against the model
        for (int n = 0; n < 3000; n++) begin
            step("R5 R6 R3 mixed", $urandom_range(0, 3) != 0, $urandom_range(0, 15),
                 {$urandom, $urandom}, $urandom_range(0, 3), $urandom_range(0, 3),
                 $urandom_range(0, 3), $urandom_range(0, 15), $urandom_range(0, 3),
                 $urandom_range(0, 15), $urandom_range(0, 3));
        end

        // R1: reset again clears everything
        @(negedge clk) rst = 1'b1;
        @(posedge clk);
        @(negedge clk) rst = 1'b0;
        for (int i = 0; i < 16; i++) model[i] = '0;
        for (int i = 0; i < 16; i += 2) step("R1 re-reset", 0, 0, 0, 3, 0, 0, i, 3, i + 1, 3);

        finish_run();
    end
endmodule